// File: doc/BRIEF.md
# Serial Status and FIFO Readout Port

This block is the device side of a three-wire host port. Through it an external microcontroller reads three things: a status byte, an OUT byte-count register and the bytes held in a small receive FIFO. The host drives a serial clock (`sck`), a select line (`sin`) and a data line toward the block (`sdi`). The block answers on `sdo` and raises an active-low interrupt when new OUT data is waiting.

While `sin` is low, pulses on `sdi` act as sync markers. One marker starts a readout at the status byte. Two or more markers start it at the count byte. The stream then runs status, count and payload, always in that order. When the last payload byte has gone out, the block drops the handshake flags so that the next OUT or Setup transaction can be accepted.

All serial inputs are asynchronous. They are brought into the system clock through two-flop synchronisers, and their edges are detected in that domain. A parallel load interface fills the FIFO, the count and the upper status bits.

Top module: `serial_readout_port`

## Requirements
- R1: After reset, `sdo` is 0 and `int_n` is 1.
- R2: A `cnt_we` load takes `cnt_len`, sets the SET flag and the OD flag, and drives `int_n` low from the next cycle. The count byte sent on the wire is {SET, length[6:0]}, so SET is bit 7. The status byte is {upper status[7:1], OD}, so OD is bit 0. A `stat_we` load writes only bits 7:1.
- R3: A single `sdi` pulse with `sin` low starts a readout. It sends the status byte, then the count byte, then FIFO entries 0 up to length-1.
- R4: Two `sdi` pulses with `sin` low start the readout at the count byte and skip the status byte. A third or later pulse has no further effect.
- R5: Each byte goes out least significant bit first. The block moves `sdo` to the next bit only after a falling `sck` edge, so the host samples on the rising edge.
- R6: `int_n` returns high only after all 8 bits of the status byte have been clocked out. A readout cut short before that point leaves `int_n` low and consumes nothing. A readout started with two pulses leaves `int_n` unchanged.
- R7: `sin` high aborts any readout and holds `sdo` low. A fresh sync after `sin` returns low starts again from the first byte.
- R8: A length of 0 means no payload. After the count byte, `sdo` stays low.
- R9: Finishing the last payload byte, or the count byte when the length is 0, clears SET and OD. The two flags fall together, and `sdo` stays low afterwards.
- R10: Any `sck` edge clears the sync-pulse counter. A pulse that follows `sck` activity therefore counts as a first pulse again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Host serial clock (asynchronous) |
| sin | input | 1 | Host select; high aborts a readout (asynchronous) |
| sdi | input | 1 | Host data line carrying sync pulses (asynchronous) |
| sdo | output | 1 | Serial readout data |
| int_n | output | 1 | Active-low new-data interrupt |
| stat_we | input | 1 | Load strobe for status bits 7:1 |
| stat_in | input | 8 | Status load value (bit 0 unused) |
| cnt_we | input | 1 | Load strobe for the OUT length; sets SET and OD |
| cnt_len | input | 7 | OUT payload length in bytes |
| fifo_we | input | 1 | FIFO entry write strobe |
| fifo_addr | input | AW | FIFO entry index |
| fifo_wdata | input | 8 | FIFO entry data |

## Verification
The bench builds the block with DEPTH = 4. At that depth a length equal to the whole FIFO can be streamed in a few hundred cycles, and lengths from 0 to the full depth are all in reach without any index wrap. The table mixes one, two and three sync pulses with different status and payload seeds. Each row ends with a re-read that shows the cleared flags. Separate directed runs cover these corners: an aborted partial status read, a pulse counter cleared by clock activity, and a zero-length transfer.

// File: rtl/serial_readout_port.sv
module serial_readout_port #(
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          sin,
  input  logic          sdi,
  output logic          sdo,
  output logic          int_n,
  input  logic          stat_we,
  input  logic [7:0]    stat_in,
  input  logic          cnt_we,
  input  logic [6:0]    cnt_len,
  input  logic          fifo_we,
  input  logic [AW-1:0] fifo_addr,
  input  logic [7:0]    fifo_wdata
);
  typedef enum logic [1:0] {SEG_STAT, SEG_CNT, SEG_DATA} seg_t;

  logic [2:0] sck_q, sin_q, sdi_q;
  logic [7:0] mem [DEPTH];
  logic [7:0] sr;
  logic [2:0] bitn;
  logic [6:0] idx, len, stat_hi;
  logic [1:0] pcnt;
  seg_t       seg;
  logic       active, irq, od, set;

  logic sin_s, sck_fall, sck_edge, sdi_rise;
  logic load_req, adv, byte_end, stat_end, xfer_end;
  logic [6:0] idx_n;
  logic [7:0] status_byte, count_byte;

  assign sin_s       = sin_q[1];
  assign sck_fall    = sck_q[2] & ~sck_q[1];
  assign sck_edge    = sck_q[2] ^ sck_q[1];
  assign sdi_rise    = sdi_q[1] & ~sdi_q[2];
  assign status_byte = {stat_hi, od};
  assign count_byte  = {set, len};
  assign idx_n       = idx + 7'd1;

  assign load_req = ~sin_s & sdi_rise & (pcnt != 2'd2);
  assign adv      = ~sin_s & ~load_req & active & sck_fall;
  assign byte_end = adv & (bitn == 3'd7);
  assign stat_end = byte_end & (seg == SEG_STAT);
  assign xfer_end = byte_end & (((seg == SEG_CNT) & (len == 7'd0)) |
                                ((seg == SEG_DATA) & (idx_n == len)));

  assign sdo   = active & sr[0];
  assign int_n = ~irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      sin_q <= '0;
      sdi_q <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      sin_q <= {sin_q[1:0], sin};
      sdi_q <= {sdi_q[1:0], sdi};
    end
  end

  always_ff @(posedge clk) begin
    if (fifo_we) mem[fifo_addr] <= fifo_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcnt <= '0;
    else if (sin_s || sck_edge)
      pcnt <= '0;
    else if (sdi_rise && pcnt != 2'd2)
      pcnt <= pcnt + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sr     <= '0;
      bitn   <= '0;
      idx    <= '0;
      seg    <= SEG_STAT;
    end else if (sin_s) begin
      active <= 1'b0;
    end else if (load_req) begin
      active <= 1'b1;
      bitn   <= '0;
      sr     <= (pcnt == 2'd0) ? status_byte : count_byte;
      seg    <= (pcnt == 2'd0) ? SEG_STAT : SEG_CNT;
    end else if (adv) begin
      if (bitn != 3'd7) begin
        sr   <= sr >> 1;
        bitn <= bitn + 3'd1;
      end else begin
        bitn <= '0;
        case (seg)
          SEG_STAT: begin
            sr  <= count_byte;
            seg <= SEG_CNT;
          end
          SEG_CNT:
            if (len == 7'd0) active <= 1'b0;
            else begin
              sr  <= mem[0];
              idx <= '0;
              seg <= SEG_DATA;
            end
          default:
            if (idx_n == len) active <= 1'b0;
            else begin
              sr  <= mem[idx_n[AW-1:0]];
              idx <= idx_n;
            end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len     <= '0;
      stat_hi <= '0;
      set     <= 1'b0;
      od      <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (stat_we) stat_hi <= stat_in[7:1];
      if (cnt_we) begin
        len <= cnt_len;
        set <= 1'b1;
        od  <= 1'b1;
        irq <= 1'b1;
      end else begin
        if (xfer_end) begin
          set <= 1'b0;
          od  <= 1'b0;
        end
        if (stat_end) irq <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_readout_port_chk.sv
module serial_readout_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sin_s,
  input logic       sdo,
  input logic       int_n,
  input logic       od,
  input logic       set,
  input logic       cnt_we,
  input logic       stat_end,
  input logic [1:0] pcnt
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (!int_n && od && set));

  p_irq_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) |-> $past(stat_end));

  p_break_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sin_s |=> !sdo);

  p_flags_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(od) |-> $fell(set));

  p_pulse_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt != 2'd3);
endmodule

bind serial_readout_port serial_readout_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sin_s    (sin_s),
  .sdo      (sdo),
  .int_n    (int_n),
  .od       (od),
  .set      (set),
  .cnt_we   (cnt_we),
  .stat_end (stat_end),
  .pcnt     (pcnt)
);

// File: tb/serial_readout_port_tb.sv
module serial_readout_port_tb;
  localparam int DEPTH = 4;
  localparam int AW = $clog2(DEPTH);
  localparam int NV = 5;
  // {pulses, length, status, data seed}
  localparam logic [31:0] VEC [NV] = '{
    32'h01_03_A4_3C, 32'h02_04_52_81, 32'h01_01_FE_00,
    32'h02_02_10_F0, 32'h03_02_00_5A };

  logic clk = 0, rst_n = 0;
  logic sck = 0, sin = 1, sdi = 0;
  logic stat_we = 0, cnt_we = 0, fifo_we = 0;
  logic [7:0] stat_in = 0, fifo_wdata = 0;
  logic [6:0] cnt_len = 0;
  logic [AW-1:0] fifo_addr = 0;
  logic sdo, int_n;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  serial_readout_port #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .sin(sin), .sdi(sdi),
    .sdo(sdo), .int_n(int_n), .stat_we(stat_we), .stat_in(stat_in),
    .cnt_we(cnt_we), .cnt_len(cnt_len), .fifo_we(fifo_we),
    .fifo_addr(fifo_addr), .fifo_wdata(fifo_wdata));

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse();
    sdi = 1; step(8);
    sdi = 0; step(8);
  endtask

  task automatic rearm();
    sin = 1; step(8);
    sin = 0; step(8);
  endtask

  task automatic read_bits(input int n, output logic [7:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      v[i] = sdo;
      sck = 1; step(8);
      sck = 0; step(8);
    end
  endtask

  task automatic load(input logic [7:0] st, input logic [6:0] ln, input logic [7:0] sd);
    stat_we = 1; stat_in = st; cnt_we = 1; cnt_len = ln;
    step(1);
    stat_we = 0; cnt_we = 0;
    for (int i = 0; i < DEPTH; i++) begin
      fifo_we = 1; fifo_addr = AW'(i); fifo_wdata = 8'(sd + i * 17);
      step(1);
    end
    fifo_we = 0;
  endtask

  initial begin
    logic [7:0] v;
    step(3);
    check("R1 sdo after reset", {7'd0, sdo}, 8'd0);
    check("R1 int_n after reset", {7'd0, int_n}, 8'd1);
    rst_n = 1;
    step(4);

    for (int k = 0; k < NV; k++) begin
      logic [7:0] p, sd, st;
      logic [6:0] ln;
      p = VEC[k][31:24]; ln = VEC[k][22:16]; st = VEC[k][15:8]; sd = VEC[k][7:0];
      load(st, ln, sd);
      check("R2 int_n after load", {7'd0, int_n}, 8'd0);
      rearm();
      for (int j = 0; j < int'(p); j++) pulse();
      if (p == 8'd1) begin
        read_bits(8, v);
        check("R3 R5 status byte", v, {st[7:1], 1'b1});
      end
      read_bits(8, v);
      check("R4 R2 count byte", v, {1'b1, ln});
      for (int i = 0; i < int'(ln); i++) begin
        read_bits(8, v);
        check("R3 payload byte", v, 8'(sd + i * 17));
      end
      read_bits(8, v);
      check("R9 sdo low after end", v, 8'd0);
      check("R6 int_n after readout", {7'd0, int_n}, (p == 8'd1) ? 8'd1 : 8'd0);
      rearm();
      pulse();
      read_bits(8, v);
      check("R9 OD cleared", v, {st[7:1], 1'b0});
      read_bits(8, v);
      check("R9 SET cleared", v, {1'b0, ln});
    end

    // R6/R7: partial status read then abort
    load(8'h80, 7'd1, 8'h11);
    rearm();
    pulse();
    read_bits(5, v);
    check("R5 partial status bits", v, 8'h01);
    sin = 1; step(8);
    check("R7 sdo low on abort", {7'd0, sdo}, 8'd0);
    check("R6 int_n held after partial", {7'd0, int_n}, 8'd0);
    sin = 0; step(8);
    pulse();
    read_bits(8, v);
    check("R7 restart at status", v, 8'h81);
    check("R6 int_n released", {7'd0, int_n}, 8'd1);

    // R10: sck activity clears the pulse counter
    load(8'h3C, 7'd2, 8'h20);
    rearm();
    pulse();
    sck = 1; step(8); sck = 0; step(8);
    pulse();
    read_bits(8, v);
    check("R10 second pulse restarts status", v, 8'h3D);

    // R8: zero length
    load(8'h06, 7'd0, 8'h77);
    rearm();
    pulse(); pulse();
    read_bits(8, v);
    check("R8 count byte zero", v, 8'h80);
    read_bits(8, v);
    check("R8 no payload follows", v, 8'h00);
    rearm();
    pulse();
    read_bits(8, v);
    check("R8 R9 OD cleared on zero length", v, 8'h06);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule